// File: doc/BRIEF.md
# Fault Escalation and Lockup Controller

This block sits beside a processor core and decides what happens when the core reports a synchronous fault. Each fault arrives tagged with a class: memory-protection, bus or usage. The block weighs the fault against three things: the per-class handler enables, the per-class priorities and the priority the core is currently running at. It then answers with the exception number to enter. That is either the class's own handler or the fixed-priority hard fault.

A hard fault that arises while the core is already in the NMI or hard-fault handler cannot be serviced. In that case the block enters lockup and stops issuing exceptions. A debug halt always ends lockup. An NMI ends it only when the lockup did not start inside the NMI handler. Reset clears everything.

The block also keeps a sticky record of usage-fault causes, which software clears by writing ones. Handler enables and the divide trap sit in two small write-only control words. Both are off after reset.

Top module: `fault_escalator`

## Requirements
- R1: After reset, `take_valid`, `take_excnum`, `ufsr` and `lockup` are zero, all three class handlers are disabled, and the divide trap is off.
- R2: A live fault is accepted when `flt_valid` is high, lockup is clear, and the fault is not an untrapped divide. When the class's handler is enabled, its priority is numerically below `cur_pri`, and the core is in neither handler, `take_valid` rises on the next clock edge. `take_excnum` is then 4 for class 0 (memory), 5 for class 1 (bus) or 6 for class 2 (usage). Class code 3 is never a fault.
- R3: Handler enables are bits 16 (memory), 17 (bus) and 18 (usage) of the word written with `hctl_we`. A live fault whose class handler is disabled is taken as exception 3.
- R4: A live fault whose class priority is equal to or numerically greater than `cur_pri` is taken as exception 3. A `cur_pri` of 8 means no exception is active.
- R5: A bus fault flagged with `flt_stacking` is taken as exception 5 whatever its priority, provided the bus handler is enabled.
- R6: A live usage fault sets its cause bit in `ufsr` on the same edge that raises `take_valid`. The cause bit is set even when the fault escalates. Cause codes map to bits as follows: 0 undefined instruction to bit 0, 1 invalid state to bit 1, 2 bad exception return to bit 2, 3 unaligned access to bit 3, 4 divide by zero to bit 4. Bits stay set until cleared.
- R7: The divide trap is bit 4 of the word written with `cctl_we`. While it is clear, a divide-by-zero usage fault causes no exception and sets no flag.
- R8: Each one in `ufsr_clr` clears that `ufsr` bit on the next edge. A cause arriving in the same cycle wins over the clear.
- R9: A live fault raised while `in_nmi` or `in_hardfault` is high always escalates. It sets `lockup` on the next edge, and `take_valid` stays low.
- R10: While `lockup` is high, `take_valid` stays low and faults change neither `ufsr` nor the lockup state.
- R11: `dbg_halt` clears `lockup` on the next edge. So does `nmi`, when the lockup was entered outside the NMI handler. Reset clears it too.
- R12: A lockup entered from the NMI handler is not left on `nmi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hctl_we | input | 1 | Write strobe for handler enables |
| hctl_wdata | input | 32 | Handler enable word, bits 18:16 |
| cctl_we | input | 1 | Write strobe for control word |
| cctl_wdata | input | 32 | Control word, bit 4 is divide trap |
| flt_valid | input | 1 | Fault request this cycle |
| flt_class | input | 2 | 0 memory, 1 bus, 2 usage |
| flt_cause | input | 3 | Usage cause code 0..4 |
| flt_stacking | input | 1 | Bus fault occurred while stacking for the bus handler |
| pri_mem | input | PRI_W | Memory fault priority |
| pri_bus | input | PRI_W | Bus fault priority |
| pri_use | input | PRI_W | Usage fault priority |
| cur_pri | input | PRI_W+1 | Current execution priority, 8 = thread |
| in_nmi | input | 1 | Core executing NMI handler |
| in_hardfault | input | 1 | Core executing hard-fault handler |
| nmi | input | 1 | NMI request |
| dbg_halt | input | 1 | Debug halt request |
| ufsr_clr | input | 5 | Write-one-to-clear for cause flags |
| take_valid | output | 1 | Exception entry decided |
| take_excnum | output | 4 | Exception number to enter |
| ufsr | output | 5 | Sticky usage cause flags |
| lockup | output | 1 | Lockup state |

## Verification
The hardest case to reach from the ports is a lockup entered from the NMI handler, where an NMI must then fail to release the block. The stimulus raises `in_nmi` and presents an escalating fault, which enters lockup. It pulses `nmi` and confirms that lockup holds. It then pulses `dbg_halt` and confirms that lockup is released. The same sequence run from the hard-fault handler shows that there an NMI does release lockup. A table of single-fault vectors covers the escalation terms (disabled class, equal and lower priority, the stacking exemption, the untrapped divide) and checks both the exception number and the cause flags.

// File: rtl/fault_escalator.sv
module fault_escalator #(
  parameter int PRI_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hctl_we,
  input  logic [31:0]      hctl_wdata,
  input  logic             cctl_we,
  input  logic [31:0]      cctl_wdata,
  input  logic             flt_valid,
  input  logic [1:0]       flt_class,
  input  logic [2:0]       flt_cause,
  input  logic             flt_stacking,
  input  logic [PRI_W-1:0] pri_mem,
  input  logic [PRI_W-1:0] pri_bus,
  input  logic [PRI_W-1:0] pri_use,
  input  logic [PRI_W:0]   cur_pri,
  input  logic             in_nmi,
  input  logic             in_hardfault,
  input  logic             nmi,
  input  logic             dbg_halt,
  input  logic [4:0]       ufsr_clr,
  output logic             take_valid,
  output logic [3:0]       take_excnum,
  output logic [4:0]       ufsr,
  output logic             lockup
);
  localparam int EN_LSB   = 16;
  localparam int TRAP_BIT = 4;
  localparam logic [3:0] EXC_HARD = 4'd3;
  localparam logic [3:0] EXC_BASE = 4'd4;
  localparam logic [2:0] CAUSE_DIV = 3'd4;

  logic [2:0]       en_q;
  logic             trap_q;
  logic             lock_nmi_q;
  logic             cls_en;
  logic [PRI_W-1:0] cls_pri;

  always_comb begin
    case (flt_class)
      2'd0:    begin cls_en = en_q[0]; cls_pri = pri_mem; end
      2'd1:    begin cls_en = en_q[1]; cls_pri = pri_bus; end
      2'd2:    begin cls_en = en_q[2]; cls_pri = pri_use; end
      default: begin cls_en = 1'b0;    cls_pri = '0;      end
    endcase
  end

  wire is_usage   = (flt_class == 2'd2);
  wire untrapped  = is_usage && (flt_cause == CAUSE_DIV) && !trap_q;
  wire live       = flt_valid && !lockup && (flt_class != 2'd3) && !untrapped;
  wire in_handler = in_nmi || in_hardfault;
  wire pri_block  = ({1'b0, cls_pri} >= cur_pri);
  wire stack_ok   = (flt_class == 2'd1) && flt_stacking;
  wire escalate   = !cls_en || in_handler || (pri_block && !stack_ok);
  wire to_lock    = live && escalate && in_handler;
  wire lock_exit  = dbg_halt || (nmi && !lock_nmi_q);
  wire [4:0] cause_set = (live && is_usage && flt_cause <= CAUSE_DIV)
                         ? (5'd1 << flt_cause) : 5'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      if (hctl_we) en_q   <= hctl_wdata[EN_LSB +: 3];
      if (cctl_we) trap_q <= cctl_wdata[TRAP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_valid  <= 1'b0;
      take_excnum <= '0;
    end else begin
      take_valid  <= live && !to_lock;
      if (live && !to_lock)
        take_excnum <= escalate ? EXC_HARD : EXC_BASE + {2'b00, flt_class};
      else
        take_excnum <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockup     <= 1'b0;
      lock_nmi_q <= 1'b0;
    end else if (lockup) begin
      if (lock_exit) begin
        lockup     <= 1'b0;
        lock_nmi_q <= 1'b0;
      end
    end else if (to_lock) begin
      lockup     <= 1'b1;
      lock_nmi_q <= in_nmi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ufsr <= '0;
    else        ufsr <= (ufsr & ~ufsr_clr) | cause_set;
  end

  p_lock_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |-> !take_valid);
  p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lockup && !dbg_halt && !nmi |=> lockup);
  p_exc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (take_excnum >= 4'd3 && take_excnum <= 4'd6));
  p_handler_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !lockup && in_handler && flt_class != 2'd3 && !untrapped |=> lockup && !take_valid);
  p_halt_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lockup && dbg_halt |=> !lockup);
  p_nmi_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lockup && lock_nmi_q && !dbg_halt |=> lockup);
  p_disabled_hard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !lockup && flt_class == 2'd0 && !en_q[0] && !in_handler |=> take_valid && take_excnum == 4'd3);
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ufsr_clr[0] && !(flt_valid && is_usage && flt_cause == 3'd0) |=> !ufsr[0]);
endmodule

// File: tb/fault_escalator_test.sv
module fault_escalator_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hctl_we = 0, cctl_we = 0;
  logic [31:0] hctl_wdata = '0, cctl_wdata = '0;
  logic flt_valid = 0, flt_stacking = 0;
  logic [1:0] flt_class = '0;
  logic [2:0] flt_cause = '0, pri_mem = 3'd7, pri_bus = 3'd7, pri_use = 3'd7;
  logic [3:0] cur_pri = 4'd8;
  logic in_nmi = 0, in_hardfault = 0, nmi = 0, dbg_halt = 0;
  logic [4:0] ufsr_clr = '0;
  logic take_valid, lockup;
  logic [3:0] take_excnum;
  logic [4:0] ufsr;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_escalator uut (.*);

  // {en[2:0], trap, cls[1:0], cause[2:0], stk, pri[2:0], cur[3:0], innmi, inhf, exp_take, exp_num[3:0]}
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {3'b111,1'b0,2'd0,3'd0,1'b0,3'd2,4'd8,1'b0,1'b0,1'b1,4'd4}, // R2 memory
    {3'b111,1'b0,2'd1,3'd0,1'b0,3'd2,4'd8,1'b0,1'b0,1'b1,4'd5}, // R2 bus
    {3'b111,1'b0,2'd2,3'd0,1'b0,3'd2,4'd8,1'b0,1'b0,1'b1,4'd6}, // R2 R6 usage
    {3'b000,1'b0,2'd0,3'd0,1'b0,3'd0,4'd8,1'b0,1'b0,1'b1,4'd3}, // R3
    {3'b101,1'b0,2'd1,3'd0,1'b0,3'd0,4'd8,1'b0,1'b0,1'b1,4'd3}, // R3 bus disabled
    {3'b111,1'b0,2'd0,3'd0,1'b0,3'd3,4'd3,1'b0,1'b0,1'b1,4'd3}, // R4 equal
    {3'b111,1'b0,2'd2,3'd1,1'b0,3'd5,4'd3,1'b0,1'b0,1'b1,4'd3}, // R4 lower, R6 flag
    {3'b111,1'b0,2'd2,3'd2,1'b0,3'd2,4'd3,1'b0,1'b0,1'b1,4'd6}, // R2 R6
    {3'b111,1'b0,2'd1,3'd0,1'b1,3'd4,4'd4,1'b0,1'b0,1'b1,4'd5}, // R5
    {3'b111,1'b0,2'd2,3'd4,1'b0,3'd0,4'd8,1'b0,1'b0,1'b0,4'd0}, // R7 untrapped
    {3'b111,1'b1,2'd2,3'd4,1'b0,3'd1,4'd8,1'b0,1'b0,1'b1,4'd6}, // R7 trapped
    {3'b010,1'b0,2'd1,3'd0,1'b1,3'd0,4'd8,1'b0,1'b0,1'b1,4'd5}, // R5 enabled
    {3'b000,1'b0,2'd1,3'd0,1'b1,3'd0,4'd8,1'b0,1'b0,1'b1,4'd3}, // R5 needs enable
    {3'b111,1'b0,2'd2,3'd3,1'b0,3'd7,4'd8,1'b0,1'b0,1'b1,4'd6}  // R2 R6 lowest pri
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [2:0] en, input logic trap);
    @(negedge clk);
    hctl_we = 1; hctl_wdata = {13'd0, en, 16'd0};
    cctl_we = 1; cctl_wdata = {27'd0, trap, 4'd0};
    @(negedge clk);
    hctl_we = 0; cctl_we = 0;
  endtask

  task automatic fault(input logic [1:0] cls, input logic [2:0] cause, input logic stk,
                       input logic [2:0] pri, input logic [3:0] cur);
    @(negedge clk);
    flt_class = cls; flt_cause = cause; flt_stacking = stk; cur_pri = cur;
    pri_mem = (cls == 2'd0) ? pri : 3'd7;
    pri_bus = (cls == 2'd1) ? pri : 3'd7;
    pri_use = (cls == 2'd2) ? pri : 3'd7;
    flt_valid = 1;
    @(negedge clk);
    flt_valid = 0; flt_stacking = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); ufsr_clr = 5'h1f;
    @(negedge clk); ufsr_clr = 5'h00;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 take_valid", take_valid, 0);
    check("R1 excnum", take_excnum, 0);
    check("R1 ufsr", ufsr, 0);
    check("R1 lockup", lockup, 0);
    fault(2'd0, 3'd0, 1'b0, 3'd0, 4'd8);
    check("R1 handlers off gives hard fault", {take_valid, take_excnum}, {1'b1, 4'd3});

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      logic [4:0] exp_u;
      v = VEC[i];
      setup(v[23:21], v[20]);
      in_nmi = v[6]; in_hardfault = v[5];
      fault(v[19:18], v[17:15], v[14], v[13:11], v[10:7]);
      check($sformatf("R2 R3 R4 R5 R7 vector %0d take", i), take_valid, v[4]);
      check($sformatf("R2 R3 R4 R5 vector %0d excnum", i), take_excnum, v[3:0]);
      exp_u = (v[19:18] == 2'd2 && !(v[17:15] == 3'd4 && !v[20])) ? (5'd1 << v[17:15]) : 5'd0;
      check($sformatf("R6 R7 vector %0d ufsr", i), ufsr, exp_u);
      pulse_clr();
      check($sformatf("R8 vector %0d cleared", i), ufsr, 0);
    end

    // R6 sticky accumulation
    setup(3'b111, 1'b1);
    fault(2'd2, 3'd0, 1'b0, 3'd1, 4'd8);
    fault(2'd2, 3'd3, 1'b0, 3'd1, 4'd8);
    check("R6 sticky two causes", ufsr, 5'b01001);
    // R8 partial clear and set-wins
    @(negedge clk); ufsr_clr = 5'b00001;
    @(negedge clk); ufsr_clr = 0;
    check("R8 partial clear", ufsr, 5'b01000);
    @(negedge clk);
    flt_class = 2'd2; flt_cause = 3'd3; pri_use = 3'd1; cur_pri = 4'd8;
    flt_valid = 1; ufsr_clr = 5'b01000;
    @(negedge clk); flt_valid = 0; ufsr_clr = 0;
    check("R8 set wins over clear", ufsr, 5'b01000);
    pulse_clr();

    // R9 lockup from hard-fault handler, R10, R11 via NMI
    in_hardfault = 1;
    fault(2'd0, 3'd0, 1'b0, 3'd0, 4'd8);
    check("R9 lockup from hard fault handler", lockup, 1);
    check("R9 no entry", take_valid, 0);
    in_hardfault = 0;
    fault(2'd2, 3'd0, 1'b0, 3'd0, 4'd8);
    check("R10 no entry in lockup", take_valid, 0);
    check("R10 no flag in lockup", ufsr, 0);
    check("R10 stays locked", lockup, 1);
    @(negedge clk); nmi = 1;
    @(negedge clk); nmi = 0;
    check("R11 nmi exits", lockup, 0);

    // R12 lockup from NMI handler
    in_nmi = 1;
    fault(2'd1, 3'd0, 1'b0, 3'd0, 4'd8);
    check("R9 lockup from nmi handler", lockup, 1);
    in_nmi = 0;
    @(negedge clk); nmi = 1;
    @(negedge clk); nmi = 0;
    check("R12 nmi does not exit", lockup, 1);
    @(negedge clk); dbg_halt = 1;
    @(negedge clk); dbg_halt = 0;
    check("R11 debug halt exits", lockup, 0);

    // R11 reset exit, R1 enables cleared by reset
    in_hardfault = 1;
    fault(2'd0, 3'd0, 1'b0, 3'd0, 4'd8);
    in_hardfault = 0;
    check("R9 relock", lockup, 1);
    do_reset();
    check("R11 reset exits", lockup, 0);
    fault(2'd2, 3'd4, 1'b0, 3'd0, 4'd8);
    check("R1 trap off after reset", take_valid, 0);
    fault(2'd1, 3'd0, 1'b0, 3'd0, 4'd8);
    check("R1 bus disabled after reset", take_excnum, 4'd3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule